// File: doc/BRIEF.md
# Fragment Quad Dispatcher

This block takes the stream of 2x2 fragment quads from a tiled rasterizer and hands each one to one of several shader units. A tile of 8x8 pixels produces its quads back to back, so there is a locality trade-off. Spreading consecutive quads across units balances the load. Keeping a run of quads on one unit keeps its texture cache warm. Any quad rejected by an early depth test has already been removed before it reaches this block.

A mode input picks the policy. In per-quad rotation, each quad goes to the next unit in cyclic order. In run-sticky mode, one unit receives quads until a configurable number of fragments has reached it, and then the pointer moves on. A quad carries four fragments, and the default run is 128 fragments, which is 32 quads.

Each unit owns a pool of input-slot credits. A dispatch uses one credit and a retire pulse from the unit returns it. When a unit has no credits left, the search skips it and goes on to the next unit that has one. The block stamps every accepted quad with a rolling sequence number so that later stages can put results back in submission order.

Top module: `quad_dispatch`

## Requirements
- R1: After reset every unit holds its full credit count, `out_seq` is 0, no `out_valid` bit is set, and the first quad offered goes to unit 0.
- R2: At most one `out_valid` bit is set at any time, and only while `in_valid` is high. The selected unit sees `out_data` equal to `in_data`.
- R3: With `sticky_mode` = 0 and credits available, consecutive accepted quads go to units 0,1,2,...,NUM_UNITS-1,0,... in that order.
- R4: With `sticky_mode` = 1 and credits available, RUN_FRAGS/4 consecutive quads go to one unit, and then the next run goes to the following unit in cyclic order.
- R5: A unit with no credits is skipped, and the quad goes to the first unit after it in cyclic order that still has credits. When the sticky run moves to a new unit this way, its fragment count starts again from zero.
- R6: When no unit has a credit, `in_ready` is low, no `out_valid` bit is set, and no quad is consumed.
- R7: A unit never has more than CREDITS quads outstanding. A one-cycle pulse on `unit_retire[u]` returns one credit to unit u, and that unit can be selected again.
- R8: `out_seq` advances by one per accepted quad and wraps modulo 2^SEQ_W.
- R9: If the selected unit has `out_ready` low, `in_ready` is low. The quad stays offered with `out_valid` high and is neither dropped nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sticky_mode | input | 1 | 0 = per-quad rotation, 1 = run-sticky assignment |
| in_valid | input | 1 | Rasterizer offers a quad |
| in_ready | output | 1 | Quad is accepted this cycle |
| in_data | input | DATA_W | Quad payload |
| out_valid | output | NUM_UNITS | One-hot offer to the selected unit |
| out_ready | input | NUM_UNITS | Per-unit acceptance |
| out_data | output | DATA_W | Payload shared by all unit ports |
| out_seq | output | SEQ_W | Sequence tag of the offered quad |
| unit_retire | input | NUM_UNITS | Per-unit credit return pulse |

## Verification
The assignment logic is tested with three patterns. In the first, credits come back after every quad. This separates rotation order from run-length order, and a run of 20 quads also wraps the sequence tag. In the second, no credits are returned. With three slots per unit against a four-quad run, units fill up before their runs end. This shows whether the skip moves to the next unit and whether the run count restarts there, since a carried count would give a short second run. In the third, one unit is held not-ready to check that the quad is held back rather than lost. After the no-credit stall, returning a single credit must send the next quad exactly to that unit.

// File: rtl/quad_dispatch_pkg.sv
package quad_dispatch_pkg;
   localparam int FRAGS_PER_QUAD = 4;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/qd_credit_ctr.sv
module qd_credit_ctr #(
   parameter int CREDITS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic give,
   output logic has_credit
);
   localparam int CW = $clog2(CREDITS + 1);
   logic [CW-1:0] level;

   always_ff @(posedge clk) begin
      if (!rst_n)
         level <= CW'(CREDITS);
      else if (take && !give)
         level <= level - 1'b1;
      else if (give && !take && level != CW'(CREDITS))
         level <= level + 1'b1;
   end

   assign has_credit = (level != '0);
endmodule

// File: rtl/qd_pick.sv
module qd_pick #(
   parameter int NUM_UNITS = 4,
   parameter int IDX_W     = 2
) (
   input  logic [IDX_W-1:0]     start,
   input  logic [NUM_UNITS-1:0] eligible,
   output logic                 found,
   output logic [IDX_W-1:0]     target
);
   generate
      if (NUM_UNITS == 1) begin : g_single
         assign found  = eligible[0];
         assign target = '0;
      end else begin : g_scan
         always_comb begin
            found  = 1'b0;
            target = start;
            for (int k = NUM_UNITS - 1; k >= 0; k--) begin
               int cand;
               cand = int'(start) + k;
               if (cand >= NUM_UNITS) cand = cand - NUM_UNITS;
               if (eligible[cand]) begin
                  found  = 1'b1;
                  target = IDX_W'(cand);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/qd_run_track.sv
module qd_run_track #(
   parameter int NUM_UNITS = 4,
   parameter int IDX_W     = 2,
   parameter int RUN_FRAGS = 128,
   parameter int SEQ_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sticky_mode,
   input  logic             fire,
   input  logic [IDX_W-1:0] target,
   output logic [IDX_W-1:0] start,
   output logic [SEQ_W-1:0] seq
);
   import quad_dispatch_pkg::*;
   localparam int CNT_W = $clog2(RUN_FRAGS + 1) + 1;

   logic [CNT_W-1:0] run_cnt, base, nxt, limit;
   logic [IDX_W-1:0] after_target;

   always_comb begin
      base  = (target == start) ? run_cnt : '0;
      nxt   = base + CNT_W'(FRAGS_PER_QUAD);
      limit = sticky_mode ? CNT_W'(RUN_FRAGS) : CNT_W'(FRAGS_PER_QUAD);
      after_target = (int'(target) == NUM_UNITS - 1) ? '0 : target + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start   <= '0;
         run_cnt <= '0;
         seq     <= '0;
      end else if (fire) begin
         seq <= seq + 1'b1;
         if (nxt >= limit) begin
            start   <= after_target;
            run_cnt <= '0;
         end else begin
            start   <= target;
            run_cnt <= nxt;
         end
      end
   end
endmodule

// File: rtl/quad_dispatch.sv
module quad_dispatch #(
   parameter int NUM_UNITS = 4,
   parameter int CREDITS   = 4,
   parameter int RUN_FRAGS = 128,
   parameter int DATA_W    = 32,
   parameter int SEQ_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sticky_mode,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [DATA_W-1:0]    in_data,
   output logic [NUM_UNITS-1:0] out_valid,
   input  logic [NUM_UNITS-1:0] out_ready,
   output logic [DATA_W-1:0]    out_data,
   output logic [SEQ_W-1:0]     out_seq,
   input  logic [NUM_UNITS-1:0] unit_retire
);
   import quad_dispatch_pkg::*;
   localparam int IDX_W = idx_width(NUM_UNITS);

   generate
      if (NUM_UNITS < 1)                       begin : g_chk_units $error("NUM_UNITS must be >= 1"); end
      if (CREDITS < 1)                         begin : g_chk_cred  $error("CREDITS must be >= 1"); end
      if (RUN_FRAGS < FRAGS_PER_QUAD ||
          (RUN_FRAGS % FRAGS_PER_QUAD) != 0)   begin : g_chk_run   $error("RUN_FRAGS must be a positive multiple of 4"); end
      if (SEQ_W < 1)                           begin : g_chk_seq   $error("SEQ_W must be >= 1"); end
   endgenerate

   logic [NUM_UNITS-1:0] unit_has_credit;
   logic [NUM_UNITS-1:0] take;
   logic [IDX_W-1:0]     start, target;
   logic                 found, fire;

   genvar u;
   generate
      for (u = 0; u < NUM_UNITS; u++) begin : g_unit
         qd_credit_ctr #(.CREDITS(CREDITS)) u_cred (
            .clk        (clk),
            .rst_n      (rst_n),
            .take       (take[u]),
            .give       (unit_retire[u]),
            .has_credit (unit_has_credit[u])
         );
         assign out_valid[u] = in_valid && found && (int'(target) == u);
         assign take[u]      = fire && (int'(target) == u);
      end
   endgenerate

   qd_pick #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) u_pick (
      .start    (start),
      .eligible (unit_has_credit),
      .found    (found),
      .target   (target)
   );

   qd_run_track #(
      .NUM_UNITS (NUM_UNITS),
      .IDX_W     (IDX_W),
      .RUN_FRAGS (RUN_FRAGS),
      .SEQ_W     (SEQ_W)
   ) u_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .sticky_mode (sticky_mode),
      .fire        (fire),
      .target      (target),
      .start       (start),
      .seq         (out_seq)
   );

   assign in_ready = found && out_ready[target];
   assign fire     = in_valid && in_ready;
   assign out_data = in_data;
endmodule

// File: rtl/qd_checker.sv
module qd_checker #(
   parameter int NUM_UNITS = 4,
   parameter int SEQ_W     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic [NUM_UNITS-1:0] out_valid,
   input logic [NUM_UNITS-1:0] out_ready,
   input logic [NUM_UNITS-1:0] has_credit,
   input logic [SEQ_W-1:0]     out_seq
);
   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_valid)); // R2
   AST_OFFER_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_valid) |-> in_valid); // R2
   AST_STALL_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (has_credit == '0) |-> (!in_ready && out_valid == '0)); // R6
   AST_ACCEPT_HAS_TAKER: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (|(out_valid & out_ready))); // R9
   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_seq == SEQ_W'($past(out_seq) + 1'b1))); // R8
   AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ready) |=> $stable(out_seq)); // R9

   genvar u;
   generate
      for (u = 0; u < NUM_UNITS; u++) begin : g_u
         AST_CREDIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[u] |-> has_credit[u]); // R7
      end
   endgenerate
endmodule

bind quad_dispatch qd_checker #(.NUM_UNITS(NUM_UNITS), .SEQ_W(SEQ_W)) u_qd_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .has_credit (unit_has_credit),
   .out_seq    (out_seq)
);

// File: tb/quad_dispatch_tb_top.sv
module quad_dispatch_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NU  = 4;
   localparam int CR  = 3;
   localparam int RUN = 16;
   localparam int DW  = 16;
   localparam int SW  = 4;

   logic clk = 1'b0;
   logic rst_n, sticky_mode, in_valid, in_ready;
   logic [DW-1:0] in_data, out_data;
   logic [NU-1:0] out_valid, out_ready, unit_retire;
   logic [SW-1:0] out_seq;

   int n_tests = 0, n_fail = 0, seq_exp = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_dispatch #(.NUM_UNITS(NU), .CREDITS(CR), .RUN_FRAGS(RUN), .DATA_W(DW), .SEQ_W(SW)) dut_i (
      .clk(clk), .rst_n(rst_n), .sticky_mode(sticky_mode), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_seq(out_seq),
      .unit_retire(unit_retire));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input bit mode);
      @(negedge clk);
      rst_n = 1'b0; sticky_mode = mode; in_valid = 1'b0; in_data = '0;
      out_ready = '1; unit_retire = '0;
      @(posedge clk); #1; rst_n = 1'b1;
      seq_exp = 0;
   endtask

   task automatic push(input int exp_u, input string req);
      @(negedge clk);
      in_valid = 1'b1; in_data = DW'(16'hA000 + seq_exp * 7);
      #1;
      chk(out_valid == NU'(1 << exp_u) && in_ready, req, int'(out_valid), 1 << exp_u);
      chk(int'(out_seq) == seq_exp % (1 << SW), "R8", int'(out_seq), seq_exp % (1 << SW));
      chk(out_data == in_data, "R2", int'(out_data), int'(in_data));
      @(posedge clk); #1;
      in_valid = 1'b0;
      seq_exp++;
   endtask

   task automatic retire(input int u);
      @(negedge clk); unit_retire = NU'(1 << u);
      @(posedge clk); #1; unit_retire = '0;
   endtask

   task automatic expect_stall(input string req);
      @(negedge clk); in_valid = 1'b1; #1;
      chk(!in_ready && out_valid == '0, req, int'(out_valid), 0);
      @(posedge clk); #1;
      chk(int'(out_seq) == seq_exp % (1 << SW), req, int'(out_seq), seq_exp % (1 << SW));
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state and first target
      do_reset(1'b0);
      @(negedge clk);
      chk(out_valid == '0, "R1", int'(out_valid), 0);
      chk(out_seq == '0, "R1", int'(out_seq), 0);
      push(0, "R1");

      // R3: rotation with prompt credit return; also wraps the tag (R8)
      do_reset(1'b0);
      for (int i = 0; i < 20; i++) begin
         push(i % NU, "R3");
         retire(i % NU);
      end

      // R4: sticky runs of RUN/4 quads with prompt return
      do_reset(1'b1);
      for (int i = 0; i < 20; i++) begin
         push((i / (RUN / 4)) % NU, "R4");
         retire((i / (RUN / 4)) % NU);
      end

      // R5/R6/R7: sticky, no returns; each unit fills after CR quads
      do_reset(1'b1);
      for (int i = 0; i < NU * CR; i++) push(i / CR, "R5");
      expect_stall("R6");
      retire(2);
      push(2, "R7");
      expect_stall("R6");

      // R5/R7: rotation, no returns
      do_reset(1'b0);
      for (int i = 0; i < NU * CR; i++) push(i % NU, "R7");
      expect_stall("R6");
      retire(1);
      push(1, "R5");

      // R9: selected unit not ready
      do_reset(1'b0);
      @(negedge clk);
      out_ready = 4'b1110; in_valid = 1'b1; #1;
      chk(out_valid == 4'b0001 && !in_ready, "R9", int'(out_valid), 1);
      @(posedge clk); #1;
      chk(out_valid == 4'b0001 && out_seq == '0, "R9", int'(out_seq), 0);
      in_valid = 1'b0; out_ready = '1;
      push(0, "R9");
      push(1, "R9");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule